// File: doc/BRIEF.md
# Serial Receive Byte Queue with Trigger Level and Idle Timeout

This block sits between a serial receiver's deserializer and the processor's data register. It holds up to sixteen received bytes in arrival order. The receive path pushes each byte with a one-cycle write strobe. The processor pops bytes with a one-cycle read strobe, and the popped byte appears on `rd_data` in the following cycle.

The block keeps three status levels. Full and empty follow the occupancy. The trigger flag is raised when an accepted byte brings the occupancy up to a programmable level. The block also drives two single-cycle event pulses. The overrun pulse marks a byte that arrived while the queue was full; that byte is discarded. The timeout pulse marks a queue that holds data but has received no byte for a set number of character times.

The length of one character time is worked out from the bit period and the frame format: data width, optional parity and one or two stop bits. The idle timer can also be restarted by a control strobe.

Top module: `rx_byte_queue`

## Requirements
- R1: Bytes leave the queue in the order they were accepted, up to DEPTH (16) entries. A byte popped by `rd_en` is on `rd_data` from the clock edge that samples `rd_en` until the next read.
- R2: A write while the queue holds DEPTH bytes stores nothing. It raises `overrun` for exactly the one cycle after that edge.
- R3: `full` is high exactly when the queue holds DEPTH bytes, so any read from a full queue clears it. `empty` is high exactly when the queue holds no bytes, so any accepted write clears it and a read that takes the last byte sets it.
- R4: `trig_flag` is set by an accepted write that leaves the occupancy at or above the trigger level. It is cleared by a read that leaves the occupancy below that level. Otherwise it holds its value.
- R5: The trigger level is loaded from `lvl_data` when `lvl_we` is high. After reset it is 32, so with the default depth the trigger flag never rises until the level is rewritten.
- R6: A read while the queue is empty puts 8'h00 on `rd_data`, and `empty` stays high.
- R7: A read and a write in the same cycle on a non-full queue leave the occupancy unchanged and move both positions. On an empty queue the read returns 8'h00 and the write is still accepted.
- R8: Each accepted write reloads the idle timer with TMO_CHARS (4) character times, counted in clock cycles. `timeout` pulses for one cycle exactly that many cycles after the loading edge. It fires only once per load, and never while the queue is empty.
- R9: One character time is `bit_cycles` × (1 start bit + data bits + parity bit + stop bits). `data_sel` 0 means 6 data bits, 1 means 7, and 2 or 3 mean 8. `parity_en` high adds one bit. `two_stop` high selects two stop bits instead of one.
- R10: A one-cycle `tmo_restart` strobe reloads the idle timer exactly as an accepted write does.
- R11: After reset the queue is empty: `empty` is 1, and `full`, `trig_flag`, `overrun`, `timeout` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push strobe from the receive path |
| wr_data | input | DATA_W | Received byte |
| rd_en | input | 1 | Pop strobe from the processor |
| rd_data | output | DATA_W | Popped byte, or zero after a read of an empty queue |
| lvl_we | input | 1 | Load strobe for the trigger level |
| lvl_data | input | LVL_W | New trigger level |
| bit_cycles | input | BIT_W | Clock cycles per serial bit |
| data_sel | input | 2 | Data width select (0: 6, 1: 7, 2/3: 8 bits) |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| tmo_restart | input | 1 | Reload the idle timer |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no bytes |
| trig_flag | output | 1 | Occupancy reached the trigger level |
| overrun | output | 1 | One-cycle pulse: a byte was dropped |
| timeout | output | 1 | One-cycle pulse: idle timer expired with data queued |

## Verification
The bench fills the queue to the brim and pushes one byte more. A design that stored that byte, or wrapped its write position onto the oldest entry, would return a corrupted sequence when the queue is drained. A design that held overrun high past one cycle would show that too. It reads from an empty queue, alone and together with a write. A design that popped stale storage, or that decremented the occupancy below zero, would return old data or lose the new byte. It checks that the trigger flag rises on the exact write that reaches the level, and that it stays low at the reset level of 32. The idle timer is measured to the exact cycle for three frame formats, after a reload by a second write, and after a restart strobe. The bench also checks that the timer stays silent once the queue is empty. An off-by-one in the reload value, a frame-length decode error, or a timer that ignored the occupancy each show up as a wrong cycle count or a stray pulse.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // data width select codes on the data_sel input
   typedef enum logic [1:0] {
      DSEL_SIX   = 2'd0,
      DSEL_SEVEN = 2'd1,
      DSEL_EIGHT = 2'd2,
      DSEL_EIGHT_ALT = 2'd3
   } dsel_e;

   // total bits on the wire for one character: start + data + parity + stop
   function automatic logic [3:0] frame_bits(input logic [1:0] dsel,
                                             input logic par,
                                             input logic two);
      logic [3:0] dbits;
      case (dsel_e'(dsel))
         DSEL_SIX:   dbits = 4'd6;
         DSEL_SEVEN: dbits = 4'd7;
         default:    dbits = 4'd8;
      endcase
      return 4'd1 + dbits + {3'b000, par} + (two ? 4'd2 : 4'd1);
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int DEPTH   = 16,
   parameter int LVL_W   = 6,
   parameter int LVL_RST = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1,
   localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             lvl_we,
   input  logic [LVL_W-1:0] lvl_data,
   output logic             accept,
   output logic             pop,
   output logic [PTR_W-1:0] waddr,
   output logic [PTR_W-1:0] raddr,
   output logic             busy_nxt,
   output logic             full,
   output logic             empty,
   output logic             trig_flag,
   output logic             overrun
);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic [PTR_W-1:0] wptr_q;
   logic [LVL_W-1:0] lvl_q;
   logic             trig_q, ovr_q;
   logic             at_level;

   assign full   = (cnt_q == CNT_W'(DEPTH));
   assign empty  = (cnt_q == '0);
   assign accept = wr_en && !full;
   assign pop    = rd_en && !empty;

   assign cnt_nxt  = cnt_q + CNT_W'(accept) - CNT_W'(pop);
   assign busy_nxt = (cnt_nxt != '0);
   assign at_level = (CMP_W'(cnt_nxt) >= CMP_W'(lvl_q));

   // read position is derived: oldest entry sits count places behind the write position
   assign waddr = wptr_q;
   assign raddr = wptr_q - cnt_q[PTR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wptr_q <= '0;
         lvl_q  <= LVL_W'(LVL_RST);
         trig_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         wptr_q <= wptr_q + PTR_W'(accept);
         ovr_q  <= wr_en && full;
         if (lvl_we) lvl_q <= lvl_data;
         if (accept && at_level)
            trig_q <= 1'b1;
         else if (pop && !at_level)
            trig_q <= 1'b0;
      end
   end

   assign trig_flag = trig_q;
   assign overrun   = ovr_q;

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
   parameter int BIT_W     = 16,
   parameter int TMO_CHARS = 4,
   localparam int CHR_W = BIT_W + 4,
   localparam int TMO_W = CHR_W + $clog2(TMO_CHARS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BIT_W-1:0] bit_cycles,
   input  logic [1:0]       data_sel,
   input  logic             parity_en,
   input  logic             two_stop,
   input  logic             load,
   input  logic             armed,
   output logic             timeout
);
   import rxq_pkg::*;

   logic [3:0]       fbits;
   logic [CHR_W-1:0] char_cyc;
   logic [TMO_W-1:0] tmo_len;
   logic [TMO_W-1:0] left_q;
   logic             fire_q;

   assign fbits    = frame_bits(data_sel, parity_en, two_stop);
   assign char_cyc = CHR_W'(bit_cycles) * CHR_W'(fbits);

   generate
      if ((TMO_CHARS & (TMO_CHARS - 1)) == 0) begin : g_shift
         assign tmo_len = TMO_W'(char_cyc) << $clog2(TMO_CHARS);
      end else begin : g_mult
         assign tmo_len = TMO_W'(char_cyc) * TMO_W'(TMO_CHARS);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= !load && (left_q == TMO_W'(1)) && armed;
         if (load)
            left_q <= tmo_len;
         else if (left_q != '0)
            left_q <= left_q - TMO_W'(1);
      end
   end

   assign timeout = fire_q;

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int LVL_W     = 6,
   parameter int LVL_RST   = 32,
   parameter int BIT_W     = 16,
   parameter int TMO_CHARS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              lvl_we,
   input  logic [LVL_W-1:0]  lvl_data,
   input  logic [BIT_W-1:0]  bit_cycles,
   input  logic [1:0]        data_sel,
   input  logic              parity_en,
   input  logic              two_stop,
   input  logic              tmo_restart,
   output logic              full,
   output logic              empty,
   output logic              trig_flag,
   output logic              overrun,
   output logic              timeout
);
   localparam int PTR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rx_byte_queue: DEPTH must be a power of two of at least 2");
      end
      if (LVL_RST >= (1 << LVL_W)) begin : g_bad_lvl
         $error("rx_byte_queue: LVL_RST does not fit in LVL_W bits");
      end
      if (TMO_CHARS < 1) begin : g_bad_tmo
         $error("rx_byte_queue: TMO_CHARS must be at least 1");
      end
      if (DATA_W < 1 || BIT_W < 1) begin : g_bad_w
         $error("rx_byte_queue: widths must be positive");
      end
   endgenerate

   logic              accept, pop, busy_nxt;
   logic [PTR_W-1:0]  waddr, raddr;
   logic [DATA_W-1:0] q_rdata;
   logic [DATA_W-1:0] rd_q;

   rxq_ctrl #(
      .DEPTH(DEPTH), .LVL_W(LVL_W), .LVL_RST(LVL_RST)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .lvl_we(lvl_we), .lvl_data(lvl_data),
      .accept(accept), .pop(pop), .waddr(waddr), .raddr(raddr),
      .busy_nxt(busy_nxt), .full(full), .empty(empty),
      .trig_flag(trig_flag), .overrun(overrun)
   );

   rxq_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH)
   ) u_store (
      .clk(clk), .we(accept), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(q_rdata)
   );

   rxq_timer #(
      .BIT_W(BIT_W), .TMO_CHARS(TMO_CHARS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .bit_cycles(bit_cycles),
      .data_sel(data_sel), .parity_en(parity_en), .two_stop(two_stop),
      .load(accept || tmo_restart), .armed(busy_nxt), .timeout(timeout)
   );

   // read data register: popped byte, or zero for a read of an empty queue
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_en)
         rd_q <= pop ? q_rdata : '0;
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              full,
   input logic              empty,
   input logic              trig_flag,
   input logic              overrun,
   input logic              timeout
);

   AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)) else $error("full and empty together"); // R3

   AST_OVR_ON_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> overrun) else $error("write to full queue without overrun"); // R2

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> full) else $error("full dropped without a read"); // R3

   AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full) |=> !empty) else $error("accepted write left queue empty"); // R3

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> (rd_data == '0)) else $error("empty read returned data"); // R6

   AST_TRIG_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_flag) |-> $past(wr_en)) else $error("trigger rose without a write"); // R4

   AST_TMO_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> !empty) else $error("timeout with empty queue"); // R8

endmodule

bind rx_byte_queue rxq_checker #(.DATA_W(DATA_W)) u_rxq_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
   .full(full), .empty(empty), .trig_flag(trig_flag), .overrun(overrun),
   .timeout(timeout)
);

// File: tb/tb_rx_byte_queue.sv
`timescale 1ns/1ps
module tb_rx_byte_queue;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic        lvl_we = 1'b0;
   logic [5:0]  lvl_data = '0;
   logic [15:0] bit_cycles = 16'd1000;
   logic [1:0]  data_sel = 2'd2;
   logic        parity_en = 1'b0;
   logic        two_stop = 1'b0;
   logic        tmo_restart = 1'b0;
   logic        full, empty, trig_flag, overrun, timeout;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   rx_byte_queue dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .lvl_we(lvl_we), .lvl_data(lvl_data),
      .bit_cycles(bit_cycles), .data_sel(data_sel), .parity_en(parity_en),
      .two_stop(two_stop), .tmo_restart(tmo_restart), .full(full),
      .empty(empty), .trig_flag(trig_flag), .overrun(overrun), .timeout(timeout)
   );

   typedef struct packed {
      logic       wr;
      logic [7:0] wd;
      logic       rd;
      logic       chk;
      logic [7:0] erd;
      logic       efull;
      logic       eempty;
      logic       etrig;
      logic       eovr;
   } vec_t;

   // trigger level 3 is loaded before this table runs
   localparam vec_t VEC [10] = '{
      '{1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b1, 8'hA2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b1, 8'hA3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
      '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b1, 8'hA4, 1'b1, 1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA4, 1'b0, 1'b1, 1'b0, 1'b0},
      '{1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
      '{1'b1, 8'hA5, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one operation: inputs held across one rising edge, returns at the next falling edge
   task automatic op(input logic w, input logic [7:0] d, input logic r, input logic rs);
      @(negedge clk);
      wr_en = w; wr_data = d; rd_en = r; tmo_restart = rs;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; tmo_restart = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_level(input logic [5:0] v);
      @(negedge clk);
      lvl_we = 1'b1; lvl_data = v;
      @(negedge clk);
      lvl_we = 1'b0;
   endtask

   // count falling edges until the timeout pulse is seen, then check its width
   task automatic measure(input string req, input int exp_n);
      int n = 0;
      while (!timeout && n < 400) begin
         @(negedge clk);
         n++;
      end
      check(req, n, exp_n);
      @(negedge clk);
      check({req, " pulse width"}, timeout, 1'b0);
   endtask

   task automatic quiet(input string req, input int cycles);
      int seen = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (timeout) seen++;
      end
      check(req, seen, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      // R11 reset state
      check("R11 empty", empty, 1'b1);
      check("R11 full", full, 1'b0);
      check("R11 trig", trig_flag, 1'b0);
      check("R11 overrun", overrun, 1'b0);
      check("R11 timeout", timeout, 1'b0);
      check("R11 rd_data", rd_data, 8'h00);

      // fill to the brim with the reset trigger level of 32
      for (int i = 0; i < 16; i++) begin
         op(1'b1, 8'h10 + 8'(i), 1'b0, 1'b0);
         check("R3 full while filling", full, (i == 15));
         check("R5 trig stays low at level 32", trig_flag, 1'b0);
      end
      op(1'b1, 8'hEE, 1'b0, 1'b0);
      check("R2 overrun pulse", overrun, 1'b1);
      check("R3 full holds after overrun", full, 1'b1);
      @(negedge clk);
      check("R2 overrun one cycle", overrun, 1'b0);
      for (int i = 0; i < 16; i++) begin
         op(1'b0, 8'h00, 1'b1, 1'b0);
         check("R1 order after overrun drop", rd_data, 8'h10 + 8'(i));
         check("R3 full cleared by read", full, 1'b0);
         check("R3 empty after drain", empty, (i == 15));
      end

      // table of stimulus and expected results, trigger level 3 (R1 R4 R6 R7)
      set_level(6'd3);
      for (int v = 0; v < 10; v++) begin
         op(VEC[v].wr, VEC[v].wd, VEC[v].rd, 1'b0);
         if (VEC[v].chk) check($sformatf("R1 R6 R7 row %0d rd_data", v), rd_data, VEC[v].erd);
         check($sformatf("R3 row %0d full", v), full, VEC[v].efull);
         check($sformatf("R3 R6 row %0d empty", v), empty, VEC[v].eempty);
         check($sformatf("R4 row %0d trig", v), trig_flag, VEC[v].etrig);
         check($sformatf("R2 row %0d overrun", v), overrun, VEC[v].eovr);
      end

      // idle timer: 2 cycles per bit, 8 data, no parity, 1 stop -> 10 bits, 4 chars = 80
      do_reset();
      bit_cycles = 16'd2; data_sel = 2'd2; parity_en = 1'b0; two_stop = 1'b0;
      op(1'b1, 8'h55, 1'b0, 1'b0);
      measure("R8 timeout after write", 80);
      quiet("R8 single pulse per load", 150);

      op(1'b1, 8'h56, 1'b0, 1'b0);
      repeat (50) @(negedge clk);
      op(1'b1, 8'h57, 1'b0, 1'b0);
      measure("R8 write reloads timer", 80);

      op(1'b1, 8'h58, 1'b0, 1'b0);
      repeat (30) @(negedge clk);
      op(1'b0, 8'h00, 1'b0, 1'b1);
      measure("R10 restart strobe reloads timer", 80);

      // 6 data bits, 1 stop -> 8 bits -> 64
      data_sel = 2'd0;
      op(1'b1, 8'h59, 1'b0, 1'b0);
      measure("R9 six data bits", 64);

      // 8 data, parity, 2 stop -> 12 bits -> 96
      data_sel = 2'd3; parity_en = 1'b1; two_stop = 1'b1;
      op(1'b1, 8'h5A, 1'b0, 1'b0);
      measure("R9 parity and two stop", 96);

      // drain, then no timeout may fire on an empty queue
      for (int i = 0; i < 6; i++) op(1'b0, 8'h00, 1'b1, 1'b0);
      check("R3 empty after timer drain", empty, 1'b1);
      op(1'b0, 8'h00, 1'b0, 1'b1);
      quiet("R8 R10 no timeout when empty after restart", 150);
      op(1'b1, 8'h77, 1'b0, 1'b0);
      op(1'b0, 8'h00, 1'b1, 1'b0);
      check("R1 byte read back", rd_data, 8'h77);
      quiet("R8 no timeout after queue emptied", 150);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule